// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block performs the processor-side entry into an interrupt handler. An arbiter in front of it presents a level request together with the event code of the winning source. The sequencer waits for an instruction boundary, indicated by a strobe from the pipeline. It then snapshots the machine context into dedicated shadow registers and records the event code. Next it builds the status word the handler runs with. Finally it issues a one-cycle redirect carrying the handler fetch address.

The status word handed back to the pipeline has three bits forced to 1: the block bit, the privileged-mode bit and the register-bank bit. Every other bit keeps its value, including the interrupt mask-level field. The fetch target is the vector base plus a fixed offset of 0x600. While the block bit of the current status is set, requests are held off. An asserted request is taken at the first boundary after software clears the bit, directly or by returning from the exception. The pipeline owns the status register: it loads `sr_o` when `redir_o` pulses and presents the live value on `sr_i`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, every shadow register, `evt_o`, `sr_o`, `redir_addr_o` and `redir_o` are zero.
- R2: A request is accepted at a rising clock edge only when `irq_req_i`, `insn_bnd_i` are both 1, bit 28 (block bit) of `sr_i` is 0, and the sequencer is idle. Without a boundary strobe, nothing is accepted.
- R3: A request that deasserts before any boundary strobe arrives causes no entry.
- R4: At acceptance, `irq_code_i` is stored in `evt_o`, visible in the cycle after the accepting edge.
- R5: At acceptance, `sr_i`, `pc_i` and `sp_i` are stored in `ssr_o`, `spc_o` and `sgr_o`, visible in the cycle after the accepting edge.
- R6: `sr_o` equals the captured status with bits 30 (privileged mode), 29 (register bank) and 28 (block) set to 1 and every other bit, including the mask field in bits 7:4, unchanged. It is valid from the second edge after acceptance.
- R7: `redir_addr_o` equals the `vbase_i` value sampled at acceptance plus 0x600, modulo 2^32.
- R8: If acceptance happens at edge n, `redir_o` is 1 between edges n+3 and n+4 and 0 in every other cycle of the sequence.
- R9: While the block bit of `sr_i` is 1, requests are ignored. A request that is still asserted is taken at the first boundary after the bit clears.
- R10: Requests and boundaries that arrive while a sequence runs are ignored, including in the redirect cycle. The shadow registers and `evt_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Interrupt request level from the arbiter |
| irq_code_i | input | 12 | Event code of the requesting source |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | Current stack-pointer register |
| vbase_i | input | 32 | Vector base value |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack pointer |
| evt_o | output | 12 | Interrupt event code register |
| sr_o | output | 32 | Status word for the handler |
| redir_o | output | 1 | One-cycle fetch redirect strobe |
| redir_addr_o | output | 32 | Handler fetch address |

## Verification
A table of accepted entries varies the mask field, the mode bits that are already set, and status words that are all zeros or nearly all ones. It also uses vector bases that are zero, typical and near the top of the address space, so that a wrong bit position, a clobbered mask or a lost carry each shows. Directed patterns separate the gating terms from each other: a request without a boundary, a boundary without a request, a request withdrawn before its boundary, and a request held under the block bit and then released. A request and boundary kept high through a whole sequence show whether a busy or redirect cycle re-captures context or starts a second entry.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned DEF_DW       = 32;
  localparam int unsigned DEF_CODE_W   = 12;
  localparam int unsigned DEF_BL_BIT   = 28;
  localparam int unsigned DEF_RB_BIT   = 29;
  localparam int unsigned DEF_MD_BIT   = 30;
  localparam int unsigned DEF_MASK_LSB = 4;
  localparam int unsigned DEF_MASK_W   = 4;
  localparam int unsigned DEF_VEC_OFF  = 32'h600;
  localparam int unsigned CTX_N        = 3;  // status, pc, stack pointer

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAVE = 2'd1,
    ST_MODE = 2'd2,
    ST_VECT = 2'd3
  } entry_state_e;
endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
  parameter int unsigned DW     = 32,
  parameter int unsigned BL_BIT = 28
) (
  input  logic          idle_i,
  input  logic          irq_req_i,
  input  logic          insn_bnd_i,
  input  logic [DW-1:0] sr_i,
  output logic          accept_o
);
  logic blocked;
  assign blocked  = sr_i[BL_BIT];
  assign accept_o = idle_i & irq_req_i & insn_bnd_i & ~blocked;
endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow #(
  parameter int unsigned DW     = 32,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned N      = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_i,
  input  logic [N-1:0][DW-1:0]  ctx_i,
  input  logic [CODE_W-1:0]     code_i,
  input  logic [DW-1:0]         vb_i,
  output logic [N-1:0][DW-1:0]  ctx_o,
  output logic [CODE_W-1:0]     code_o,
  output logic [DW-1:0]         vb_o
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (cap_i) q <= ctx_i[g];
    end
    assign ctx_o[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      vb_o   <= '0;
    end else if (cap_i) begin
      code_o <= code_i;
      vb_o   <= vb_i;
    end
  end

  // R4
  evt_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> code_o == $past(code_i));
endmodule

// File: rtl/irq_mode_vector.sv
module irq_mode_vector #(
  parameter int unsigned DW      = 32,
  parameter int unsigned BL_BIT  = 28,
  parameter int unsigned RB_BIT  = 29,
  parameter int unsigned MD_BIT  = 30,
  parameter int unsigned VEC_OFF = 32'h600
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_en_i,
  input  logic          vec_en_i,
  input  logic [DW-1:0] ssr_i,
  input  logic [DW-1:0] vb_i,
  output logic [DW-1:0] sr_o,
  output logic [DW-1:0] tgt_o
);
  localparam logic [DW-1:0] SET_MASK = (DW'(1) << BL_BIT) | (DW'(1) << RB_BIT) | (DW'(1) << MD_BIT);
  localparam logic [DW-1:0] OFF      = DW'(VEC_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o  <= '0;
      tgt_o <= '0;
    end else begin
      if (mode_en_i) sr_o  <= ssr_i | SET_MASK;
      if (vec_en_i)  tgt_o <= vb_i + OFF;  // wraps modulo 2^DW
    end
  end

  // R6
  mode_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_en_i |=> sr_o[BL_BIT] && sr_o[RB_BIT] && sr_o[MD_BIT]);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned DW       = DEF_DW,
  parameter int unsigned CODE_W   = DEF_CODE_W,
  parameter int unsigned BL_BIT   = DEF_BL_BIT,
  parameter int unsigned RB_BIT   = DEF_RB_BIT,
  parameter int unsigned MD_BIT   = DEF_MD_BIT,
  parameter int unsigned MASK_LSB = DEF_MASK_LSB,
  parameter int unsigned MASK_W   = DEF_MASK_W,
  parameter int unsigned VEC_OFF  = DEF_VEC_OFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic              insn_bnd_i,
  input  logic [DW-1:0]     sr_i,
  input  logic [DW-1:0]     pc_i,
  input  logic [DW-1:0]     sp_i,
  input  logic [DW-1:0]     vbase_i,
  output logic [DW-1:0]     ssr_o,
  output logic [DW-1:0]     spc_o,
  output logic [DW-1:0]     sgr_o,
  output logic [CODE_W-1:0] evt_o,
  output logic [DW-1:0]     sr_o,
  output logic              redir_o,
  output logic [DW-1:0]     redir_addr_o
);
  localparam int unsigned MASK_MSB = MASK_LSB + MASK_W - 1;

  entry_state_e state_q, state_d;
  logic redir_q, idle, accept;
  logic [CTX_N-1:0][DW-1:0] ctx_in, ctx_sv;
  logic [DW-1:0] vb_sv;

  assign idle = (state_q == ST_IDLE) && !redir_q;  // redirect cycle counts as busy

  irq_accept_gate #(.DW(DW), .BL_BIT(BL_BIT)) u_gate (
    .idle_i     (idle),
    .irq_req_i  (irq_req_i),
    .insn_bnd_i (insn_bnd_i),
    .sr_i       (sr_i),
    .accept_o   (accept)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_SAVE;
      ST_SAVE: state_d = ST_MODE;
      ST_MODE: state_d = ST_VECT;
      ST_VECT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      redir_q <= 1'b0;
    end else begin
      state_q <= state_d;
      redir_q <= (state_q == ST_VECT);
    end
  end

  assign ctx_in[0] = sr_i;
  assign ctx_in[1] = pc_i;
  assign ctx_in[2] = sp_i;

  irq_ctx_shadow #(.DW(DW), .CODE_W(CODE_W), .N(CTX_N)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (accept),
    .ctx_i  (ctx_in),
    .code_i (irq_code_i),
    .vb_i   (vbase_i),
    .ctx_o  (ctx_sv),
    .code_o (evt_o),
    .vb_o   (vb_sv)
  );

  assign ssr_o = ctx_sv[0];
  assign spc_o = ctx_sv[1];
  assign sgr_o = ctx_sv[2];

  irq_mode_vector #(
    .DW(DW), .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT), .VEC_OFF(VEC_OFF)
  ) u_modevec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_en_i (state_q == ST_SAVE),
    .vec_en_i  (state_q == ST_MODE),
    .ssr_i     (ctx_sv[0]),
    .vb_i      (vb_sv),
    .sr_o      (sr_o),
    .tgt_o     (redir_addr_o)
  );

  assign redir_o = redir_q;

  // R8
  redir_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |=> !redir_o);

  // R2
  no_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !(irq_req_i && insn_bnd_i && !sr_i[BL_BIT])) |=> state_q == ST_IDLE);

  // R6
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> sr_o[MASK_MSB:MASK_LSB] == ssr_o[MASK_MSB:MASK_LSB] && sr_o[BL_BIT]);

  // R10
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> $stable(ssr_o) && $stable(spc_o) && $stable(sgr_o) && $stable(evt_o));

  // R7
  target_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |-> $stable(redir_addr_o));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 4;
  localparam logic [31:0] SETB = 32'h7000_0000;
  // {code, sr, pc, sp, vbase}
  localparam logic [139:0] VEC [NV] = '{
    {12'h240, 32'h0000_00F0, 32'h8C00_1000, 32'h8C0F_FFF0, 32'h8000_0000},
    {12'h5A0, 32'h4000_0031, 32'h0000_2222, 32'h1234_5678, 32'h0000_0000},
    {12'hFFF, 32'h8FFF_FF0F, 32'hA5A5_5A5A, 32'hFFFF_FFFC, 32'h1234_5000},
    {12'h001, 32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_0000, 32'hFFFF_FC00}
  };

  logic clk = 0, rst_n = 0;
  logic req = 0, bnd = 0;
  logic [11:0] code = '0;
  logic [31:0] sr = '0, pc = '0, sp = '0, vb = '0;
  logic [31:0] ssr, spc, sgr, sr_n, tgt;
  logic [11:0] evt;
  logic redir;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .irq_code_i(code), .insn_bnd_i(bnd),
    .sr_i(sr), .pc_i(pc), .sp_i(sp), .vbase_i(vb),
    .ssr_o(ssr), .spc_o(spc), .sgr_o(sgr), .evt_o(evt), .sr_o(sr_n),
    .redir_o(redir), .redir_addr_o(tgt)
  );

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // counts redirect pulses over n cycles
  task automatic count_redir(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin tick(); if (redir) hits++; end
  endtask

  // full accepted entry with one-cycle boundary; checks R4..R8
  task automatic entry(input logic [139:0] v);
    logic [31:0] esr, epc, esp, evb;
    logic [11:0] ecode;
    {ecode, esr, epc, esp, evb} = v;
    code = ecode; sr = esr; pc = epc; sp = esp; vb = evb;
    req = 1; bnd = 1;
    tick();  // accept edge n
    req = 0; bnd = 0; code = ~ecode; pc = ~epc; sp = ~esp; vb = ~evb;
    chk(evt == ecode, "R4", 32'(evt), 32'(ecode));
    chk(ssr == esr && spc == epc && sgr == esp, "R5", ssr ^ spc ^ sgr, esr ^ epc ^ esp);
    chk(!redir, "R8", 32'(redir), 0);
    tick();  // n+1
    chk(sr_n == (esr | SETB), "R6", sr_n, esr | SETB);
    chk(sr_n[7:4] == esr[7:4], "R6 mask", 32'(sr_n[7:4]), 32'(esr[7:4]));
    tick();  // n+2
    chk(!redir, "R8", 32'(redir), 0);
    tick();  // n+3
    chk(redir == 1'b1, "R8", 32'(redir), 1);
    chk(tgt == evb + 32'h600, "R7", tgt, evb + 32'h600);
    sr = sr_n;  // pipeline loads the handler status
    tick();  // n+4
    chk(!redir, "R8", 32'(redir), 0);
    sr = esr;   // return from exception clears the block bit
  endtask

  initial begin
    int hits;
    #(CLK_PERIOD * 2.5);
    chk(ssr == 0 && spc == 0 && sgr == 0 && evt == 0 && sr_n == 0 && tgt == 0 && !redir,
        "R1", ssr | spc | sgr | sr_n | tgt, 0);
    rst_n = 1;
    tick();

    for (int i = 0; i < NV; i++) entry(VEC[i]);

    // R2: boundary without request, request without boundary
    sr = 0; code = 12'h3C3; req = 0; bnd = 1;
    count_redir(6, hits);
    chk(hits == 0 && evt == 12'h001, "R2 no request", 32'(hits), 0);
    req = 1; bnd = 0;
    count_redir(6, hits);
    chk(hits == 0 && evt == 12'h001, "R2 no boundary", 32'(hits), 0);

    // R3: request withdrawn, then boundary comes
    req = 0; bnd = 1;
    count_redir(6, hits);
    chk(hits == 0 && evt == 12'h001, "R3", 32'(evt), 32'h001);
    bnd = 0;

    // R9: block bit held high
    sr = 32'h1000_00A0; pc = 32'h0000_4444; req = 1; bnd = 1; code = 12'h777;
    count_redir(8, hits);
    chk(hits == 0 && evt == 12'h001, "R9 blocked", 32'(evt), 32'h001);
    sr = 32'h0000_00A0;
    tick();  // accept edge
    chk(evt == 12'h777 && ssr == 32'h0000_00A0, "R9 released", 32'(evt), 32'h777);
    code = 12'h0AB; pc = 32'hDEAD_0000;  // R10: req and bnd still high during sequence
    count_redir(3, hits);
    chk(hits == 1 && redir, "R10 single redirect", 32'(hits), 1);
    chk(evt == 12'h777 && spc == 32'h0000_4444, "R10 hold", 32'(evt), 32'h777);
    sr = sr_n;  // handler status: block set
    count_redir(6, hits);
    chk(hits == 0 && evt == 12'h777, "R10 after", 32'(hits), 0);
    req = 0; bnd = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 5000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule